// File: doc/BRIEF.md
# Configurable Product-Term Logic Cell

This block is one logic cell of a simulated complex programmable logic device. A wide configuration word chooses, for each of eight product terms, which signals take part and whether each one is used true or inverted. The signals come from a shared signal bus and from a small set of shared expander terms. Three of the terms are summed. The sum passes through a polarity XOR whose second input is another product term. The XOR result then feeds a storage element. That element can act as a D, T, JK or SR flip-flop, as a flow-through latch, or as a plain combinational path.

Four further terms supply a preset, a clear, a private clock and an output enable. The cell drives its value to a pin driver and feeds the same value back to the local array. The output enable is passed on for the pin driver outside the block. Everything runs on the system clock. When the private clock is selected, its rising edges are found by comparing its value across system-clock edges.

Top module: `pt_macrocell`

## Requirements
- R1: The term inputs form the vector `{exp_in, bus_in}`: bus bit i is input i, and expander bit j is input BUS_W+j. Term k occupies `cfg_in[k*2*IN_W +: 2*IN_W]`. The low IN_W bits of that field select the inputs that take part. The high IN_W bits invert the matching inputs. The term is the AND of its selected, optionally inverted inputs. A term with no selected inputs evaluates to 1.
- R2: Terms 0, 1 and 2 are ORed, and a term with no selected inputs adds 0 to the OR. The sum is XORed with term 3 (polarity), and an unused polarity term counts as 0.
- R3: The mode is `cfg_in[16*IN_W +: 3]`. In mode 0 (D), with the system clock selected, the output takes the XOR result at each clock edge.
- R4: In mode 1 (T), the stored value inverts at each active edge when the XOR result is 1. It holds when the XOR result is 0.
- R5: In mode 2 (JK), J is the term sum and K is the polarity term. At each active edge, 00 holds, 10 sets, 01 clears and 11 toggles.
- R6: In mode 3 (SR), S is the term sum and R is the polarity term. 10 sets, 01 clears, and both 00 and 11 hold the stored value.
- R7: In mode 4 (latch), the output follows the XOR result while term 6 (clock) is 1. While term 6 is 0, the output keeps the value captured at the last system-clock edge at which term 6 was 1.
- R8: In mode 5 (bypass), the output equals the XOR result with no clock delay. Codes 6 and 7 behave the same way.
- R9: Term 4 (preset) forces the output to 1 and term 5 (clear) forces it to 0, both at once and without a clock edge. Clear wins over preset. An unused preset or clear term is inactive. The forced value stays stored after the force is released.
- R10: Bit `cfg_in[16*IN_W+3]` selects the clock: 0 for the system clock, 1 for term 6. With term 6 selected, the flip-flop modes update only at a system-clock edge where term 6 is 1 and was 0 at the previous edge. A term 6 that stays high causes no further updates.
- R11: `oe_out` equals term 7, and an unused term 7 gives 1. `fb_out` always equals `cell_out`, whatever the state of `oe_out`.
- R12: A synchronous active-high `rst` clears the stored value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | BUS_W | Shared signal bus |
| exp_in | input | EXP_W | Shared expander term values |
| cfg_in | input | 16*(BUS_W+EXP_W)+4 | Configuration word: term fields, mode, clock select |
| cell_out | output | 1 | Cell value toward the pin driver |
| fb_out | output | 1 | Cell value fed back to the array |
| oe_out | output | 1 | Enable for the three-state pin driver |

## Verification
The term logic is run in bypass mode over all eight combinations of a true bus input, an inverted bus input and an expander input. This separates a correct AND/OR structure from wrong inversion, a wrong bit mapping or an unused term leaking into the sum. The polarity term is then toggled under a fixed sum to confirm the XOR. Each register mode gets a sequence that passes through every control combination, including JK toggle and SR hold on both controls high, so that the modes cannot be mistaken for one another. Separate scenarios overlap preset with clear, hold the private clock high across several edges, and drop the latch gate while the data changes, each of which shows a different ordering fault.

// File: rtl/pt_pkg.sv
package pt_pkg;

  typedef enum logic [2:0] {
    MODE_D     = 3'd0,
    MODE_T     = 3'd1,
    MODE_JK    = 3'd2,
    MODE_SR    = 3'd3,
    MODE_LATCH = 3'd4,
    MODE_COMB  = 3'd5
  } cell_mode_e;

  localparam int MODE_W    = 3;
  localparam int NUM_TERMS = 8;
  localparam int NUM_SUM   = 3;

  // term slots in the configuration word
  localparam int TI_POL = 3;
  localparam int TI_PRE = 4;
  localparam int TI_CLR = 5;
  localparam int TI_CLK = 6;
  localparam int TI_OE  = 7;

endpackage

// File: rtl/pt_term.sv
module pt_term #(
  parameter int IN_W = 12
) (
  input  logic [IN_W-1:0] sig,
  input  logic [IN_W-1:0] sel,
  input  logic [IN_W-1:0] inv,
  output logic            prod,
  output logic            used
);

  logic [IN_W-1:0] lit;

  // unselected inputs are forced to 1 so they drop out of the AND
  always_comb begin
    lit  = (sig ^ inv) | ~sel;
    prod = &lit;
    used = |sel;
  end

endmodule

// File: rtl/pt_store.sv
module pt_store
  import pt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              arr_clk_sel,
  input  logic              x_in,
  input  logic              s_in,
  input  logic              r_in,
  input  logic              ck_in,
  input  logic              pre_in,
  input  logic              clr_in,
  output logic              q_out
);

  logic ck_prev;
  logic state;
  logic tick;
  logic reg_mode;

  // private clock is oversampled by the system clock; tracked through reset
  always_ff @(posedge clk) begin
    ck_prev <= ck_in;
  end

  always_comb begin
    tick     = arr_clk_sel ? (ck_in & ~ck_prev) : 1'b1;
    reg_mode = (mode == MODE_D) || (mode == MODE_T) ||
               (mode == MODE_JK) || (mode == MODE_SR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= 1'b0;
    end else if (clr_in) begin
      state <= 1'b0;
    end else if (pre_in) begin
      state <= 1'b1;
    end else if (reg_mode) begin
      if (tick) begin
        case (mode)
          MODE_D:  state <= x_in;
          MODE_T:  state <= state ^ x_in;
          MODE_JK: begin
            case ({s_in, r_in})
              2'b10:   state <= 1'b1;
              2'b01:   state <= 1'b0;
              2'b11:   state <= ~state;
              default: state <= state;
            endcase
          end
          default: begin
            case ({s_in, r_in})
              2'b10:   state <= 1'b1;
              2'b01:   state <= 1'b0;
              default: state <= state;
            endcase
          end
        endcase
      end
    end else if (mode == MODE_LATCH) begin
      if (ck_in) state <= x_in;
    end else begin
      state <= x_in;
    end
  end

  // forcing terms act on the output without waiting for an edge
  always_comb begin
    if (clr_in)                           q_out = 1'b0;
    else if (pre_in)                      q_out = 1'b1;
    else if (mode == MODE_LATCH)          q_out = ck_in ? x_in : state;
    else if (!reg_mode)                   q_out = x_in;
    else                                  q_out = state;
  end

endmodule

// File: rtl/pt_macrocell.sv
module pt_macrocell
  import pt_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int EXP_W = 4,
  localparam int IN_W   = BUS_W + EXP_W,
  localparam int TERM_W = 2 * IN_W,
  localparam int MODE_LSB = NUM_TERMS * TERM_W,
  localparam int CFG_W  = MODE_LSB + MODE_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] bus_in,
  input  logic [EXP_W-1:0] exp_in,
  input  logic [CFG_W-1:0] cfg_in,
  output logic             cell_out,
  output logic             fb_out,
  output logic             oe_out
);

  logic [IN_W-1:0]      sig_all;
  logic [NUM_TERMS-1:0] prod;
  logic [NUM_TERMS-1:0] used;
  logic [MODE_W-1:0]    mode_sel;
  logic                 clk_src;
  logic                 sum_val;
  logic                 pol_val;
  logic                 x_val;
  logic                 ck_term;
  logic                 pre_act;
  logic                 clr_act;
  logic                 q_val;

  assign sig_all  = {exp_in, bus_in};
  assign mode_sel = cfg_in[MODE_LSB +: MODE_W];
  assign clk_src  = cfg_in[MODE_LSB + MODE_W];

  for (genvar k = 0; k < NUM_TERMS; k++) begin : g_term
    pt_term #(.IN_W(IN_W)) u_term (
      .sig  (sig_all),
      .sel  (cfg_in[k*TERM_W +: IN_W]),
      .inv  (cfg_in[k*TERM_W + IN_W +: IN_W]),
      .prod (prod[k]),
      .used (used[k])
    );
  end

  always_comb begin
    sum_val = |(prod[NUM_SUM-1:0] & used[NUM_SUM-1:0]);
    pol_val = prod[TI_POL] & used[TI_POL];
    x_val   = sum_val ^ pol_val;
    pre_act = prod[TI_PRE] & used[TI_PRE];
    clr_act = prod[TI_CLR] & used[TI_CLR];
    ck_term = prod[TI_CLK];
  end

  pt_store u_store (
    .clk         (clk),
    .rst         (rst),
    .mode        (mode_sel),
    .arr_clk_sel (clk_src),
    .x_in        (x_val),
    .s_in        (sum_val),
    .r_in        (pol_val),
    .ck_in       (ck_term),
    .pre_in      (pre_act),
    .clr_in      (clr_act),
    .q_out       (q_val)
  );

  assign cell_out = q_val;
  assign fb_out   = q_val;
  assign oe_out   = prod[TI_OE];

endmodule

// File: rtl/pt_macrocell_chk.sv
module pt_macrocell_chk (
  input logic       clk,
  input logic       rst,
  input logic       cell_out,
  input logic [2:0] mode,
  input logic       arr_clk,
  input logic       xo,
  input logic       ck_t,
  input logic       pre_a,
  input logic       clr_a
);

  logic d_sys, d_arr, is_latch, is_comb, no_force;

  always_comb begin
    d_sys    = (mode == 3'd0) && !arr_clk;
    d_arr    = (mode == 3'd0) && arr_clk;
    is_latch = (mode == 3'd4);
    is_comb  = (mode >= 3'd5);
    no_force = !pre_a && !clr_a;
  end

  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clr_a |-> !cell_out);

  // R9
  preset_forces_chk: assert property (@(posedge clk) disable iff (rst)
    (pre_a && !clr_a) |-> cell_out);

  // R3
  d_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (d_sys && no_force) ##1 (d_sys && no_force) |-> (cell_out == $past(xo)));

  // R10
  arr_clk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (d_arr && no_force && !$rose(ck_t)) ##1 (d_arr && no_force) |-> $stable(cell_out));

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (is_latch && !ck_t && no_force) ##1 (is_latch && !ck_t && no_force) |-> $stable(cell_out));

  // R8
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (is_comb && no_force) |-> (cell_out == xo));

endmodule

bind pt_macrocell pt_macrocell_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cell_out (cell_out),
  .mode     (mode_sel),
  .arr_clk  (clk_src),
  .xo       (x_val),
  .ck_t     (ck_term),
  .pre_a    (pre_act),
  .clr_a    (clr_act)
);

// File: tb/pt_macrocell_tb.sv
module pt_macrocell_tb;

  localparam int BUS_W  = 8;
  localparam int EXP_W  = 4;
  localparam int IN_W   = BUS_W + EXP_W;
  localparam int TERM_W = 2 * IN_W;
  localparam int MLSB   = 8 * TERM_W;
  localparam int CFG_W  = MLSB + 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [BUS_W-1:0] bus_in = '0;
  logic [EXP_W-1:0] exp_in = '0;
  logic [CFG_W-1:0] cfg_in = '0;
  logic             cell_out, fb_out, oe_out;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  pt_macrocell #(.BUS_W(BUS_W), .EXP_W(EXP_W)) u_dut (
    .clk(clk), .rst(rst), .bus_in(bus_in), .exp_in(exp_in), .cfg_in(cfg_in),
    .cell_out(cell_out), .fb_out(fb_out), .oe_out(oe_out)
  );

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic set_term(input int k, input logic [IN_W-1:0] sel, input logic [IN_W-1:0] inv);
    cfg_in[k*TERM_W +: IN_W]        = sel;
    cfg_in[k*TERM_W + IN_W +: IN_W] = inv;
  endtask

  task automatic set_mode(input logic [2:0] m, input logic src);
    cfg_in[MLSB +: 3] = m;
    cfg_in[MLSB + 3]  = src;
  endtask

  task automatic fresh();
    cfg_in = '0;
    bus_in = '0;
    exp_in = '0;
  endtask

  task automatic t_reset();
    fresh();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    step();
    chk(cell_out, 1'b0, "R12", "output after reset");
    chk(oe_out, 1'b1, "R11", "unused enable term");
    set_term(0, 12'h001, 12'h000);
    bus_in = 8'h01;
    step();
    chk(cell_out, 1'b1, "R3", "D load before reset");
    rst = 1'b1;
    step();
    chk(cell_out, 1'b0, "R12", "reset clears stored one");
    rst = 1'b0;
  endtask

  task automatic t_terms();
    fresh();
    set_mode(3'd5, 1'b0);
    set_term(0, 12'h003, 12'h002);   // bus0 & ~bus1
    set_term(1, 12'h100, 12'h000);   // exp0
    for (int p = 0; p < 8; p++) begin
      bus_in[0] = p[0];
      bus_in[1] = p[1];
      exp_in[0] = p[2];
      #1;
      chk(cell_out, (p[0] & ~p[1]) | p[2], "R1", "term sum pattern");
      chk(fb_out, cell_out, "R11", "feedback equals output");
    end
    set_term(3, 12'h080, 12'h000);   // polarity = bus7
    for (int p = 0; p < 4; p++) begin
      bus_in    = '0;
      exp_in    = '0;
      bus_in[0] = p[0];
      bus_in[7] = p[1];
      #1;
      chk(cell_out, p[0] ^ p[1], "R2", "polarity xor");
    end
    set_mode(3'd7, 1'b0);
    bus_in = 8'h01;
    #1;
    chk(cell_out, 1'b1, "R8", "unused mode code bypasses");
    set_mode(3'd5, 1'b0);
    set_term(7, 12'h080, 12'h080);   // enable = ~bus7
    bus_in = 8'h81;
    #1;
    chk(oe_out, 1'b0, "R11", "enable low");
    chk(cell_out, 1'b0, "R8", "output with enable low");
    chk(fb_out, 1'b0, "R11", "feedback with enable low");
    bus_in = 8'h01;
    #1;
    chk(oe_out, 1'b1, "R11", "enable high");
  endtask

  task automatic t_dff();
    fresh();
    set_mode(3'd0, 1'b0);
    set_term(0, 12'h001, 12'h000);
    set_term(3, 12'h002, 12'h000);
    step();
    bus_in = 8'h01;
    #1;
    chk(cell_out, 1'b0, "R3", "no change before edge");
    step();
    chk(cell_out, 1'b1, "R3", "loads one");
    bus_in = 8'h03;
    step();
    chk(cell_out, 1'b0, "R3", "loads inverted by polarity");
    bus_in = 8'h02;
    step();
    chk(cell_out, 1'b1, "R3", "polarity alone");
  endtask

  task automatic init_zero(input logic [2:0] m);
    fresh();
    set_mode(m, 1'b0);
    set_term(5, 12'h040, 12'h000);   // clear = bus6
    bus_in = 8'h40;
    step();
    bus_in = 8'h00;
  endtask

  task automatic t_tff();
    init_zero(3'd1);
    set_term(0, 12'h001, 12'h000);
    chk(cell_out, 1'b0, "R4", "T start");
    bus_in = 8'h01;
    step(); chk(cell_out, 1'b1, "R4", "toggle 1");
    step(); chk(cell_out, 1'b0, "R4", "toggle 2");
    step(); chk(cell_out, 1'b1, "R4", "toggle 3");
    bus_in = 8'h00;
    step(); chk(cell_out, 1'b1, "R4", "hold with zero");
  endtask

  task automatic t_jk();
    init_zero(3'd2);
    set_term(0, 12'h001, 12'h000);   // J
    set_term(3, 12'h002, 12'h000);   // K
    bus_in = 8'h01; step(); chk(cell_out, 1'b1, "R5", "JK set");
    bus_in = 8'h00; step(); chk(cell_out, 1'b1, "R5", "JK hold");
    bus_in = 8'h02; step(); chk(cell_out, 1'b0, "R5", "JK clear");
    bus_in = 8'h03; step(); chk(cell_out, 1'b1, "R5", "JK toggle up");
    step();                 chk(cell_out, 1'b0, "R5", "JK toggle down");
  endtask

  task automatic t_sr();
    init_zero(3'd3);
    set_term(0, 12'h001, 12'h000);   // S
    set_term(3, 12'h002, 12'h000);   // R
    bus_in = 8'h01; step(); chk(cell_out, 1'b1, "R6", "SR set");
    bus_in = 8'h03; step(); chk(cell_out, 1'b1, "R6", "SR both hold one");
    bus_in = 8'h02; step(); chk(cell_out, 1'b0, "R6", "SR reset");
    bus_in = 8'h03; step(); chk(cell_out, 1'b0, "R6", "SR both hold zero");
    bus_in = 8'h00; step(); chk(cell_out, 1'b0, "R6", "SR idle");
  endtask

  task automatic t_latch();
    fresh();
    set_mode(3'd4, 1'b0);
    set_term(0, 12'h001, 12'h000);
    set_term(6, 12'h004, 12'h000);   // gate = bus2
    bus_in = 8'h05;
    #1; chk(cell_out, 1'b1, "R7", "transparent high");
    bus_in = 8'h04;
    #1; chk(cell_out, 1'b0, "R7", "transparent low");
    bus_in = 8'h05;
    step();
    bus_in = 8'h00;
    #1; chk(cell_out, 1'b1, "R7", "holds after gate drop");
    step(); chk(cell_out, 1'b1, "R7", "holds across edge");
    bus_in = 8'h04;
    #1; chk(cell_out, 1'b0, "R7", "reopens");
  endtask

  task automatic t_force();
    fresh();
    set_mode(3'd0, 1'b0);
    set_term(0, 12'h001, 12'h000);
    set_term(4, 12'h010, 12'h000);   // preset = bus4
    set_term(5, 12'h020, 12'h000);   // clear = bus5
    step();
    chk(cell_out, 1'b0, "R9", "unused-force baseline");
    bus_in = 8'h10;
    #1; chk(cell_out, 1'b1, "R9", "preset without edge");
    step();
    bus_in = 8'h30;
    #1; chk(cell_out, 1'b0, "R9", "clear beats preset");
    step();
    bus_in = 8'h10;
    #1; chk(cell_out, 1'b1, "R9", "preset after clear release");
    step();
    bus_in = 8'h00;
    #1; chk(cell_out, 1'b1, "R9", "preset value kept");
    step(); chk(cell_out, 1'b0, "R9", "next edge loads data");
  endtask

  task automatic t_aclk();
    init_zero(3'd0);
    set_mode(3'd0, 1'b1);
    set_term(0, 12'h001, 12'h000);
    set_term(6, 12'h008, 12'h000);   // clock = bus3
    bus_in = 8'h01;
    step(); step();
    chk(cell_out, 1'b0, "R10", "no private edge");
    bus_in = 8'h09;
    step(); chk(cell_out, 1'b1, "R10", "rising private edge");
    bus_in = 8'h08;
    step(); step();
    chk(cell_out, 1'b1, "R10", "steady high clock");
    bus_in = 8'h00;
    step(); chk(cell_out, 1'b1, "R10", "falling edge ignored");
    bus_in = 8'h08;
    step(); chk(cell_out, 1'b0, "R10", "second rising edge");
  endtask

  initial begin
    #4000000;
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #5;
    t_reset();
    t_terms();
    t_dff();
    t_tff();
    t_jk();
    t_sr();
    t_latch();
    t_force();
    t_aclk();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule